// File: doc/BRIEF.md
# Memory Training Sequencer with Status Word

This block drives the top-level state machine of a memory interface training flow. A training command, accepted only while the machine is idle, starts a fixed series of four training steps. Each step waits for a single-cycle done pulse, with a pass bit alongside it, from an external step engine. A step that fails does not stop the series: the machine notes the outcome and moves on. After the fourth step the machine goes back to idle and raises a sequence-complete flag.

Two calibration commands are tracked on their own, apart from training: impedance calibration and long ZQ calibration. Each has an issue pulse and a finish pulse, and each owns one completion flag. The current state code, the four step pass flags, the completion flag and both calibration flags are packed into one read-only 32-bit status word. The status word is a pure function of registered state, so it changes one clock after the event that causes it. All pins are plain control and status signals. No stream interface exists, so there is no back-pressure.

Top module: `mem_train_status`

## Requirements
- R1: After reset, every bit of `status_word` and `cur_step` is 0.
- R2: A `train_cmd` taken in idle (code 000) moves the state to code 001 on the next clock. On the same edge it clears pass bits 6:3 and the completion bit 8.
- R3: The state codes run 001 read DQ-DQS, 010 receive-enable bitlock, 011 write leveling, 100 write DQ-DQS, then 000 idle. The state advances only on a clock where `step_done` is high, and otherwise holds. `status_word[2:0]` and `cur_step` always show this code.
- R4: The pass bits are bit 3 for code 001, bit 4 for 010, bit 5 for 011 and bit 6 for 100. A pass bit sets only when `step_done` and `step_pass` are both high in its own step. A failed step leaves its bit clear, and the sequence still advances.
- R5: Bit 8 sets on the clock that leaves code 100, whether or not any step passed. It stays set until the next accepted training command.
- R6: A `train_cmd` while the state is not 000 is ignored. The state, the pass bits and bit 8 are unchanged by it.
- R7: A `step_done` pulse while in idle has no effect on any status bit.
- R8: Bit 7, long ZQ calibration complete, clears on the clock after `zql_issue` and sets on the clock after `zql_finish`. If both are high together, issue wins and the bit clears.
- R9: Bit 9, impedance calibration complete, follows the same rule with `imp_issue` and `imp_finish`.
- R10: `status_word[31:10]` always reads 0.
- R11: Training commands do not change bits 7 and 9. Calibration pulses do not change bits 0 to 6 or bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_cmd | input | 1 | Training command pulse |
| step_done | input | 1 | Step engine done pulse |
| step_pass | input | 1 | Outcome of the current step, valid with step_done |
| zql_issue | input | 1 | Long ZQ calibration issued |
| zql_finish | input | 1 | Long ZQ calibration finished |
| imp_issue | input | 1 | Impedance calibration issued |
| imp_finish | input | 1 | Impedance calibration finished |
| cur_step | output | 3 | Current state code |
| status_word | output | 32 | Packed read-only status |

## Verification
The hardest situations to reach are coincidences: a training command arriving on the same clock as the last done pulse, a done pulse while the machine is idle, and issue and finish of one calibration in the same cycle. Directed sequences place these pulses on exactly those clocks. A long phase then drives every input with independent random pulses. A behavioural model built from integers follows every cycle of that phase, and it compares the whole status word and the state code on each clock.

// File: rtl/mtrn_pkg.sv
package mtrn_pkg;
  localparam int NUM_STEPS = 4;
  localparam int NUM_CAL   = 2;
  localparam int STATE_W   = 3;
  localparam int WORD_W    = 32;

  // Bit positions decoded by software
  localparam int PASS_LSB = 3;
  localparam int ZQL_BIT  = 7;
  localparam int SEQ_BIT  = 8;
  localparam int IMP_BIT  = 9;

  // Calibration index within the tracker array
  localparam int CAL_ZQL = 0;
  localparam int CAL_IMP = 1;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE   = 3'd0,
    ST_RD_DQ  = 3'd1,
    ST_RCV_EN = 3'd2,
    ST_WR_LVL = 3'd3,
    ST_WR_DQ  = 3'd4
  } train_state_e;
endpackage

// File: rtl/train_seq_fsm.sv
module train_seq_fsm
  import mtrn_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         train_cmd,
  input  logic         step_done,
  output train_state_e state,
  output logic         start,
  output logic         seq_done
);
  train_state_e nxt;

  assign start = (state == ST_IDLE) && train_cmd;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (train_cmd) nxt = ST_RD_DQ;
      ST_RD_DQ:  if (step_done) nxt = ST_RCV_EN;
      ST_RCV_EN: if (step_done) nxt = ST_WR_LVL;
      ST_WR_LVL: if (step_done) nxt = ST_WR_DQ;
      ST_WR_DQ:  if (step_done) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      seq_done <= 1'b0;
    end else begin
      state <= nxt;
      if (start)
        seq_done <= 1'b0;
      else if (state == ST_WR_DQ && step_done)
        seq_done <= 1'b1;
    end
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state inside {ST_IDLE, ST_RD_DQ, ST_RCV_EN, ST_WR_LVL, ST_WR_DQ}); // R3
  AST_HOLD_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && !step_done) |=> $stable(state)); // R3
  AST_START_STEP1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && train_cmd) |=> (state == ST_RD_DQ && !seq_done)); // R2
  AST_LAST_STEP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR_DQ && step_done) |=> (state == ST_IDLE && seq_done)); // R5
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && state != ST_WR_DQ && train_cmd) |=> $stable(seq_done)); // R6
endmodule

// File: rtl/step_pass_bank.sv
module step_pass_bank
  import mtrn_pkg::*;
#(
  parameter int STEPS = NUM_STEPS
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step_done,
  input  logic             step_pass,
  input  train_state_e     state,
  output logic [STEPS-1:0] flags
);
  for (genvar i = 0; i < STEPS; i++) begin : g_step
    localparam logic [STATE_W-1:0] MY_CODE = STATE_W'(i + 1);
    logic hit;
    assign hit = (state == MY_CODE) && step_done && step_pass;

    always_ff @(posedge clk) begin
      if (!rst_n)     flags[i] <= 1'b0;
      else if (clear) flags[i] <= 1'b0;
      else if (hit)   flags[i] <= 1'b1;
    end

    AST_PASS_ONLY_IN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[i]) |-> ($past(state) == MY_CODE && $past(step_pass))); // R4
  end

  AST_FAIL_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && step_done && !step_pass) |=> $stable(flags)); // R4
  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (flags == '0)); // R2
endmodule

// File: rtl/cal_done_flag.sv
module cal_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic finish,
  output logic done
);
  always_ff @(posedge clk) begin
    if (!rst_n)      done <= 1'b0;
    else if (issue)  done <= 1'b0;
    else if (finish) done <= 1'b1;
  end

  AST_ISSUE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !done); // R8, R9
  AST_FINISH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !issue) |=> done); // R8, R9
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!finish && !issue) |=> $stable(done)); // R11
endmodule

// File: rtl/mem_train_status.sv
module mem_train_status
  import mtrn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              train_cmd,
  input  logic              step_done,
  input  logic              step_pass,
  input  logic              zql_issue,
  input  logic              zql_finish,
  input  logic              imp_issue,
  input  logic              imp_finish,
  output logic [STATE_W-1:0] cur_step,
  output logic [WORD_W-1:0]  status_word
);
  train_state_e         state;
  logic                 start;
  logic                 seq_done;
  logic [NUM_STEPS-1:0] pass_flags;
  logic [NUM_CAL-1:0]   cal_issue, cal_finish, cal_done;

  train_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .train_cmd(train_cmd), .step_done(step_done),
    .state(state), .start(start), .seq_done(seq_done)
  );

  step_pass_bank #(.STEPS(NUM_STEPS)) u_pass (
    .clk(clk), .rst_n(rst_n), .clear(start), .step_done(step_done),
    .step_pass(step_pass), .state(state), .flags(pass_flags)
  );

  always_comb begin
    cal_issue           = '0;
    cal_finish          = '0;
    cal_issue[CAL_ZQL]  = zql_issue;
    cal_finish[CAL_ZQL] = zql_finish;
    cal_issue[CAL_IMP]  = imp_issue;
    cal_finish[CAL_IMP] = imp_finish;
  end

  for (genvar c = 0; c < NUM_CAL; c++) begin : g_cal
    cal_done_flag u_cal (
      .clk(clk), .rst_n(rst_n), .issue(cal_issue[c]),
      .finish(cal_finish[c]), .done(cal_done[c])
    );
  end

  always_comb begin
    status_word                            = '0;
    status_word[STATE_W-1:0]               = state;
    status_word[PASS_LSB +: NUM_STEPS]     = pass_flags;
    status_word[ZQL_BIT]                   = cal_done[CAL_ZQL];
    status_word[SEQ_BIT]                   = seq_done;
    status_word[IMP_BIT]                   = cal_done[CAL_IMP];
  end

  assign cur_step = state;

  AST_TRAIN_LEAVES_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    (train_cmd && !zql_issue && !zql_finish && !imp_issue && !imp_finish)
      |=> $stable(cal_done)); // R11
  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !train_cmd && step_done)
      |=> ($stable(pass_flags) && $stable(seq_done) && state == ST_IDLE)); // R7
endmodule

// File: tb/test_mem_train_status.sv
module test_mem_train_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic train_cmd = 0, step_done = 0, step_pass = 0;
  logic zql_issue = 0, zql_finish = 0, imp_issue = 0, imp_finish = 0;
  logic [2:0]  cur_step;
  logic [31:0] status_word;

  int n_checks = 0, n_errors = 0, cycles = 0;
  bit finished = 0;

  // reference model state
  int m_state = 0;
  bit m_pass[4];
  bit m_cmpl = 0, m_zql = 0, m_imp = 0;

  always #2.5 clk = ~clk;

  mem_train_status i_mem_train_status (
    .clk(clk), .rst_n(rst_n), .train_cmd(train_cmd), .step_done(step_done),
    .step_pass(step_pass), .zql_issue(zql_issue), .zql_finish(zql_finish),
    .imp_issue(imp_issue), .imp_finish(imp_finish),
    .cur_step(cur_step), .status_word(status_word)
  );

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    w[2:0] = 3'(m_state);
    for (int k = 0; k < 4; k++) w[3+k] = m_pass[k];
    w[7] = m_zql;
    w[8] = m_cmpl;
    w[9] = m_imp;
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [31:0] e = model_word();
    logic [31:0] d = status_word ^ e;
    string tag;
    if      (d[31:10] != 0) tag = "R10 upper bits";
    else if (d[2:0]   != 0) tag = "R3 state code";
    else if (d[6:3]   != 0) tag = "R4 pass flags";
    else if (d[7])          tag = "R8 zq long flag";
    else if (d[8])          tag = "R5 completion flag";
    else if (d[9])          tag = "R9 impedance flag";
    else                    tag = "R11 status word";
    check(d == 0, tag, status_word, e);
    check(cur_step == 3'(m_state), "R3 cur_step", 32'(cur_step), 32'(m_state));
  endtask

  task automatic model_step();
    if (m_state == 0) begin
      if (train_cmd) begin
        m_state = 1; m_cmpl = 0;
        for (int k = 0; k < 4; k++) m_pass[k] = 0;
      end
    end else if (step_done) begin
      if (step_pass) m_pass[m_state-1] = 1;
      if (m_state == 4) begin m_state = 0; m_cmpl = 1; end
      else m_state++;
    end
    if (zql_issue) m_zql = 0; else if (zql_finish) m_zql = 1;
    if (imp_issue) m_imp = 0; else if (imp_finish) m_imp = 1;
  endtask

  // one cycle: inputs applied at negedge, model advanced at posedge, compare at next negedge
  task automatic cyc(input bit tc, input bit d, input bit p,
                     input bit zi, input bit zf, input bit ii, input bit iff_);
    train_cmd = tc; step_done = d; step_pass = p;
    zql_issue = zi; zql_finish = zf; imp_issue = ii; imp_finish = iff_;
    @(posedge clk);
    model_step();
    @(negedge clk);
    train_cmd = 0; step_done = 0; step_pass = 0;
    zql_issue = 0; zql_finish = 0; imp_issue = 0; imp_finish = 0;
    compare_all();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      finish_run();
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) m_pass[k] = 0;
    repeat (3) @(negedge clk);
    check(status_word == 0 && cur_step == 0, "R1 reset value", status_word, 0);
    rst_n = 1;
    @(negedge clk);
    check(status_word == 0, "R1 after release", status_word, 0);

    // R7: done in idle
    cyc(0, 1, 1, 0, 0, 0, 0);
    check(status_word == 0, "R7 idle done ignored", status_word, 0);

    // full pass sequence with idle gaps
    cyc(1, 0, 0, 0, 0, 0, 0);
    check(status_word[2:0] == 3'd1, "R2 start code", status_word, 1);
    for (int s = 0; s < 4; s++) begin
      cyc(0, 0, 1, 0, 0, 0, 0);
      cyc(0, 1, 1, 0, 0, 0, 0);
    end
    check(status_word == 32'h0000_0178, "R5 all passed", status_word, 32'h178);

    // failing pattern: pass, fail, pass, fail; restart clears flags
    cyc(1, 0, 0, 0, 0, 0, 0);
    check(status_word == 32'h1, "R2 clear on start", status_word, 32'h1);
    cyc(0, 1, 1, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    check(status_word == 32'h0A, "R6 busy command ignored", status_word, 32'h0A);
    cyc(0, 1, 0, 0, 0, 0, 0);
    cyc(0, 1, 1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0);
    check(status_word == 32'h128, "R4 failures recorded, R5 sets anyway", status_word, 32'h128);

    // all fail
    cyc(1, 0, 0, 0, 0, 0, 0);
    for (int s = 0; s < 4; s++) cyc(0, 1, 0, 0, 0, 0, 0);
    check(status_word == 32'h100, "R5 complete with no passes", status_word, 32'h100);

    // calibration flags
    cyc(0, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0);
    check(status_word[7] == 1'b1, "R8 zq long set", status_word, 32'h180);
    cyc(0, 0, 0, 1, 1, 0, 0);
    check(status_word[7] == 1'b0, "R8 issue wins", status_word, 32'h100);
    cyc(0, 0, 0, 0, 0, 0, 1);
    check(status_word[9] == 1'b1, "R9 impedance set", status_word, 32'h300);
    cyc(0, 0, 0, 0, 1, 1, 1);
    check(status_word == 32'h180, "R9 issue wins, R8 independent", status_word, 32'h180);
    cyc(1, 0, 0, 0, 0, 0, 0);
    check(status_word == 32'h81, "R11 training keeps zq flag", status_word, 32'h81);
    cyc(0, 0, 0, 1, 0, 1, 0);
    check(status_word == 32'h1, "R11 cal leaves training", status_word, 32'h1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] r = 7'($urandom);
      cyc(r[0] & r[1], r[2], r[3], ($urandom_range(7) == 0), ($urandom_range(5) == 0),
          ($urandom_range(7) == 0), ($urandom_range(5) == 0));
    end
    check(status_word[31:10] == 0, "R10 upper zero", status_word, 0);

    // mid-sequence reset returns to zero
    cyc(1, 0, 0, 1, 1, 0, 1);
    rst_n = 0;
    @(negedge clk);
    m_state = 0; m_cmpl = 0; m_zql = 0; m_imp = 0;
    for (int k = 0; k < 4; k++) m_pass[k] = 0;
    check(status_word == 0, "R1 reset mid run", status_word, 0);
    finish_run();
  end
endmodule